// File: doc/BRIEF.md
# Single-Channel Block Transfer Controller

This block moves a programmed number of words between one peripheral and memory so that the processor does not have to copy each one. Software loads a starting memory address and a word count. It then writes a control word. That word picks the direction and whether the block keeps the bus for a whole run (burst) or gives it back after every word (cycle stealing). Its go bit arms the channel.

Once armed, the block waits for the peripheral's request. It then asks the processor for the bus and waits for the grant. Only after the grant does it acknowledge the peripheral and perform a memory access at the current address. After every word the address counts up by one and the remaining count counts down by one. When the count runs out, the channel returns to idle and raises a completion interrupt. That interrupt stays high until software clears it.

The control flow is one state machine with four states. IDLE: not armed. WAIT: armed, with no bus request. BREQ: bus request raised, waiting for the grant. XFER: one word per cycle, with acknowledge and memory enable asserted. Its transitions are:
- IDLE to WAIT on go with a nonzero count.
- IDLE to IDLE on go with a zero count, which raises the interrupt.
- WAIT to BREQ when the request is seen.
- BREQ to XFER when the grant is seen.
- XFER to XFER in burst mode while the request stays high and words remain.
- XFER to WAIT after a word in cycle-stealing mode, or in burst mode when the request has dropped.
- XFER to IDLE after the last word, which raises the interrupt.

Top module: `blk_xfer_ctrl`

## Requirements
- R1: After reset, busy, bus_req, dev_ack, mem_en and eot_irq are all 0.
- R2: A write with cfg_sel=0 loads the start address. A write with cfg_sel=1 loads the word count. A write with cfg_sel=2 loads the control word: bit0=1 means device-to-memory and 0 means memory-to-device; bit1=1 means burst and 0 means cycle stealing; bit2=1 starts the channel. A write with cfg_sel=3 clears eot_irq.
- R3: bus_req is raised only after dev_req has been seen while armed. dev_ack and mem_en are asserted only while bus_grant is high.
- R4: The n-th word moved (counting from 0) uses mem_addr = start address + n. Exactly as many words are moved as the loaded count.
- R5: mem_we is 1 during every word of a device-to-memory run and 0 during every word of a memory-to-device run.
- R6: In burst mode, while dev_req stays high, bus_req stays high from the first word to the last word, and words follow in consecutive cycles.
- R7: In cycle-stealing mode, every word is followed by at least one cycle with bus_req low, so each grant covers one word.
- R8: In burst mode, if dev_req is low when a word finishes and words remain, bus_req drops. The run resumes with a new bus request when dev_req returns.
- R9: After the last word the block returns to idle (busy=0) and sets eot_irq. eot_irq stays 1 until a write with cfg_sel=3.
- R10: A go with a word count of zero sets eot_irq at once, leaves busy at 0, and never raises bus_req.
- R11: While busy, writes with cfg_sel 0, 1 and 2 are ignored, so the running address sequence and the word total do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 address, 1 count, 2 control, 3 clear interrupt) |
| cfg_wdata | input | AW | Register write data |
| dev_req | input | 1 | Peripheral transfer request |
| dev_ack | output | 1 | Acknowledge to peripheral, high during each word |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address of the current word |
| mem_en | output | 1 | Memory access enable, one cycle per word |
| mem_we | output | 1 | 1 = memory write (device to memory), 0 = memory read |
| busy | output | 1 | Channel armed or transferring |
| eot_irq | output | 1 | End-of-transfer interrupt, held until cleared |

## Verification
The assertions assume that the processor side keeps bus_grant high for as long as bus_req stays high once granted, and lowers it only after bus_req falls. They also assume that grant never arrives without a request. The bench meets both assumptions with a grant model that is simply bus_req delayed by one clock. The peripheral request is driven only at falling edges, and register writes last a single cycle, so every input the controller samples is stable around the rising edge.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BREQ = 2'd2,
        ST_XFER = 2'd3
    } xfer_state_t;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_CLR   = 2'd3;

    localparam int CTRL_DIR_BIT   = 0;
    localparam int CTRL_BURST_BIT = 1;
    localparam int CTRL_GO_BIT    = 2;
endpackage

// File: rtl/blk_xfer_regs.sv
module blk_xfer_regs
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic          dir_to_mem,
    output logic          burst_mode,
    output logic          go,
    output logic          clr_irq,
    output logic          cnt_zero,
    output logic          cnt_last
);
    logic [CW-1:0] cnt_q;
    logic          wr_open;

    assign wr_open  = cfg_we && !busy;
    assign go       = wr_open && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_GO_BIT];
    assign clr_irq  = cfg_we && (cfg_sel == SEL_CLR);
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            cnt_q      <= '0;
            dir_to_mem <= 1'b0;
            burst_mode <= 1'b0;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
        end else if (wr_open) begin
            unique case (cfg_sel)
                SEL_ADDR:  addr_q <= cfg_wdata;
                SEL_COUNT: cnt_q  <= cfg_wdata[CW-1:0];
                SEL_CTRL: begin
                    dir_to_mem <= cfg_wdata[CTRL_DIR_BIT];
                    burst_mode <= cfg_wdata[CTRL_BURST_BIT];
                end
                SEL_CLR:   ;
            endcase
        end
    end

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> ($stable(addr_q) && $stable(cnt_q))); // R11
    AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((cnt_q == $past(cnt_q) - CW'(1)) && (addr_q == $past(addr_q) + AW'(1)))); // R4
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dir_to_mem) && $stable(burst_mode))); // R5
endmodule

// File: rtl/blk_xfer_fsm.sv
module blk_xfer_fsm
    import blk_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic clr_irq,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic burst_mode,
    input  logic dir_to_mem,
    input  logic dev_req,
    input  logic bus_grant,
    output logic busy,
    output logic step,
    output logic bus_req,
    output logic dev_ack,
    output logic mem_en,
    output logic mem_we,
    output logic eot_irq
);
    xfer_state_t state_q, state_d;
    logic        set_irq;

    always_comb begin
        state_d = state_q;
        set_irq = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (cnt_zero) set_irq = 1'b1;
                    else          state_d = ST_WAIT;
                end
            end
            ST_WAIT: if (dev_req)   state_d = ST_BREQ;
            ST_BREQ: if (bus_grant) state_d = ST_XFER;
            ST_XFER: begin
                if (cnt_last) begin
                    state_d = ST_IDLE;
                    set_irq = 1'b1;
                end else if (burst_mode && dev_req) begin
                    state_d = ST_XFER;
                end else begin
                    state_d = ST_WAIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            eot_irq <= 1'b0;
        end else begin
            state_q <= state_d;
            if (set_irq)      eot_irq <= 1'b1;
            else if (clr_irq) eot_irq <= 1'b0;
        end
    end

    always_comb begin
        busy    = 1'b1;
        step    = 1'b0;
        bus_req = 1'b0;
        dev_ack = 1'b0;
        mem_en  = 1'b0;
        mem_we  = 1'b0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_WAIT: ;
            ST_BREQ: bus_req = 1'b1;
            ST_XFER: begin
                bus_req = 1'b1;
                dev_ack = 1'b1;
                mem_en  = 1'b1;
                mem_we  = dir_to_mem;
                step    = 1'b1;
            end
        endcase
    end

    AST_ACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack || mem_en) |-> bus_grant); // R3
    AST_BR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(dev_req)); // R3
    AST_BURST_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && burst_mode && dev_req && !cnt_last) |=> (mem_en && bus_req)); // R6
    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !burst_mode) |=> !bus_req); // R7
    AST_BURST_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && burst_mode && !dev_req && !cnt_last) |=> !bus_req); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_irq && !clr_irq) |=> eot_irq); // R9
    AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && cnt_last) |=> (!busy && eot_irq)); // R9
    AST_ZERO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt_zero && !busy) |=> (!busy && eot_irq)); // R10
endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dev_req,
    output logic          dev_ack,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] mem_addr,
    output logic          mem_en,
    output logic          mem_we,
    output logic          busy,
    output logic          eot_irq
);
    logic step, go, clr_irq, cnt_zero, cnt_last, dir_to_mem, burst_mode;

    blk_xfer_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .step       (step),
        .addr_q     (mem_addr),
        .dir_to_mem (dir_to_mem),
        .burst_mode (burst_mode),
        .go         (go),
        .clr_irq    (clr_irq),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last)
    );

    blk_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .clr_irq    (clr_irq),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .burst_mode (burst_mode),
        .dir_to_mem (dir_to_mem),
        .dev_req    (dev_req),
        .bus_grant  (bus_grant),
        .busy       (busy),
        .step       (step),
        .bus_req    (bus_req),
        .dev_ack    (dev_ack),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .eot_irq    (eot_irq)
    );
endmodule

// File: tb/sim_blk_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_blk_xfer_ctrl;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dev_req = 1'b0;
    logic          bus_grant = 1'b0;
    logic          dev_ack, bus_req, mem_en, mem_we, busy, eot_irq;
    logic [AW-1:0] mem_addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    blk_xfer_ctrl #(.AW(AW), .CW(12)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
        .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr),
        .mem_en(mem_en), .mem_we(mem_we), .busy(busy), .eot_irq(eot_irq)
    );

    // processor model: grant follows request one clock later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_grant <= 1'b0;
        else        bus_grant <= bus_req;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // run an armed channel; log every word; optional hold-off, pause, and busy-time writes
    task automatic run_xfer(input string tag, input logic [AW-1:0] base, input int nwords,
                            input bit to_mem, input int hold_off, input int pause_at,
                            input bit inject, input int exp_rises);
        int n = 0, addr_err = 0, we_err = 0, grant_err = 0, early_br = 0, rises = 0;
        int pause_left = 0, inj = 0;
        bit prev_br = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (k > 0 && !busy) break;
            if (k < hold_off && bus_req) early_br++;
            if (bus_req && !prev_br) rises++;
            prev_br = bus_req;
            if ((mem_en || dev_ack) && !bus_grant) grant_err++;
            if (mem_en) begin
                if (mem_addr != base + AW'(n)) addr_err++;
                if (mem_we != to_mem) we_err++;
                n++;
                if (n == pause_at) pause_left = 5;
                if (inject && n == 1) inj = 1;
            end
            cfg_we = 1'b0;
            if (inj == 1) begin cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h0999; inj = 2; end
            else if (inj == 2) begin cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'd9; inj = 3; end
            else if (inj == 3) begin cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'h0007; inj = 4; end
            if (pause_left > 0) begin dev_req = 1'b0; pause_left--; end
            else dev_req = (k + 1 >= hold_off);
        end
        cfg_we = 1'b0;
        dev_req = 1'b0;
        check({tag, " R3 no bus_req before dev_req"}, early_br, 0);
        check({tag, " R3 ack/mem_en only with grant"}, grant_err, 0);
        check({tag, " R4 word total"}, n, nwords);
        check({tag, " R4 address sequence errors"}, addr_err, 0);
        check({tag, " R5 direction errors"}, we_err, 0);
        check({tag, " R6/R7/R8 bus_req rises"}, rises, exp_rises);
        check({tag, " R9 idle after last word"}, busy, 0);
        check({tag, " R9 irq set"}, eot_irq, 1);
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 bus_req", bus_req, 0);
        check("R1 dev_ack", dev_ack, 0);
        check("R1 mem_en", mem_en, 0);
        check("R1 eot_irq", eot_irq, 0);
    endtask

    task automatic t_irq_clear;
        repeat (6) @(negedge clk);
        check("R9 irq held", eot_irq, 1);
        cfg_write(2'd3, '0);
        check("R9 irq cleared", eot_irq, 0);
    endtask

    task automatic t_burst_in;
        cfg_write(2'd0, 16'h0100);
        cfg_write(2'd1, 16'd4);
        cfg_write(2'd2, 16'h0007); // R2: to memory, burst, go
        check("R2 armed", busy, 1);
        run_xfer("burst_in", 16'h0100, 4, 1'b1, 8, 0, 1'b0, 1);
        t_irq_clear();
    endtask

    task automatic t_steal_out;
        cfg_write(2'd0, 16'h0020);
        cfg_write(2'd1, 16'd3);
        cfg_write(2'd2, 16'h0004); // from memory, cycle stealing, go
        run_xfer("steal_out", 16'h0020, 3, 1'b0, 0, 0, 1'b0, 3);
        t_irq_clear();
    endtask

    task automatic t_burst_pause;
        cfg_write(2'd0, 16'hFFFE);
        cfg_write(2'd1, 16'd5);
        cfg_write(2'd2, 16'h0006); // from memory, burst, go; address wraps
        run_xfer("burst_pause R8", 16'hFFFE, 5, 1'b0, 0, 2, 1'b0, 2);
        t_irq_clear();
    endtask

    task automatic t_ignore_busy;
        cfg_write(2'd0, 16'h0040);
        cfg_write(2'd1, 16'd3);
        cfg_write(2'd2, 16'h0005); // to memory, cycle stealing, go
        run_xfer("ignore R11", 16'h0040, 3, 1'b1, 0, 0, 1'b1, 3);
        t_irq_clear();
    endtask

    task automatic t_single;
        cfg_write(2'd0, 16'h0300);
        cfg_write(2'd1, 16'd1);
        cfg_write(2'd2, 16'h0003); // burst, to memory, no go bit
        repeat (3) @(negedge clk);
        check("R2 no go bit stays idle", busy, 0);
        cfg_write(2'd2, 16'h0007);
        run_xfer("single R4", 16'h0300, 1, 1'b1, 2, 0, 1'b0, 1);
        t_irq_clear();
    endtask

    task automatic t_zero;
        int br_seen = 0, busy_seen = 0;
        cfg_write(2'd1, 16'd0);
        dev_req = 1'b1;
        cfg_write(2'd2, 16'h0006);
        check("R10 irq at once", eot_irq, 1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (bus_req) br_seen++;
            if (busy) busy_seen++;
        end
        dev_req = 1'b0;
        check("R10 no bus_req", br_seen, 0);
        check("R10 never busy", busy_seen, 0);
        cfg_write(2'd3, '0);
        check("R10 irq cleared", eot_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst_in();
        t_steal_out();
        t_burst_pause();
        t_ignore_busy();
        t_single();
        t_zero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule